// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block gathers up to 96 single-cycle hardware event pulses into sticky status bits. It presents them to software through a small synchronous register bus that has an address, a write enable, write data and combinational read data. Software clears an event by writing a one to its status bit. Bits written as zero are left alone.

Three independent mask groups all look at the same status bits, and each group drives its own level-sensitive interrupt line. Line A (`irq_o[0]`) is the high-priority line, followed by line B (`irq_o[1]`) and line C (`irq_o[2]`). For each line a read-only vector register reports the lowest-numbered event that is both pending and enabled. The interrupt handler can read it directly instead of scanning the status bits.

Top module: `evt_irq_aggr`

## Requirements
- R1: An event pulse on `evt_i[n]` sets status bit n%32 of status word n/32 at the next clock edge. Status word k is read at byte offset 4*k, for offsets 0x00, 0x04 and 0x08.
- R2: A status bit stays set until software clears it. Writing 0 to a status bit leaves it unchanged.
- R3: A write to a status word clears, at that clock edge, every bit whose write-data bit is 1.
- R4: If an event pulse and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R5: Mask group g (0..2) holds three read/write words at offsets 0x10*(g+1) + 4*k. Word k of a group parallels status word k.
- R6: `irq_o[g]` is 1 exactly while some status bit is set and the matching bit of mask group g is also set. It rises and falls at the same edge that changes that condition.
- R7: The vector register for line g is at offset 0x40 + 4*g and is read-only. Bit 7 is a valid flag and bits 6:0 hold the lowest event number n for which status and mask group g are both set. Bits 31:8 read 0. When no such event exists the whole register reads 0.
- R8: Reads of any offset not listed above return 0, and writes to such offsets change no state.
- R9: After reset, all status and mask words read 0 and every `irq_o` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 96 | Single-cycle event pulses, bit n is event n |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write enable for the current address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 3 | Interrupt lines A, B, C (bit 0 = A) |

## Verification
Every result follows from a single register stage. A pulse or write presented before edge t shows up in the status, in `irq_o`, in the vector registers and in `rdata_o` straight after edge t, with no further latency. The bench drives its inputs and compares outputs on the falling edge, so each comparison sees the state left by the previous rising edge. The behavioural model advances exactly once per rising edge, using the same inputs the design sampled. Directed cases cover these patterns:
- a pulse and a clear arriving together;
- a mask write that removes the last contributor to a line;
- vector priority when events in different words are pending.

A random phase follows, and it compares `irq_o` and the addressed read data on every cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned WORDS_DEF  = 3;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned LINES_DEF  = 3;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned GRP_STRIDE = 16;  // byte stride between mask groups
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned EVT_N = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] evt_i,
  input  logic [EVT_N-1:0] clr_i,
  output logic [EVT_N-1:0] status_o
);
  logic [EVT_N-1:0] status_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | evt_i;

  assign status_o = status_q;

  p_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));
  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((status_q & $past(clr_i & ~evt_i)) == '0));
  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & clr_i)) |=> ((status_q & $past(evt_i & clr_i)) == $past(evt_i & clr_i)));
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
  parameter int unsigned WORDS  = 3,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned EVT_N = WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORDS-1:0]  wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [EVT_N-1:0]  mask_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] mask_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)      mask_q <= '0;
      else if (wr_i[w]) mask_q <= wdata_i;
    assign mask_o[w*WORD_W +: WORD_W] = mask_q;

    p_mask_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i[w] |=> (mask_q == $past(wdata_i)));
  end
endmodule

// File: rtl/evt_line_scan.sv
module evt_line_scan #(
  parameter int unsigned EVT_N = 96,
  localparam int unsigned IDX_W = $clog2(EVT_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] pend_i,
  output logic             irq_o,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins: scan downward, last hit kept
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = EVT_N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assign irq_o = |pend_i;

  logic [EVT_N-1:0] below;
  assign below = ({{(EVT_N-1){1'b0}}, 1'b1} << idx_o) - 1'b1;

  p_vec_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> pend_i[idx_o]);
  p_vec_lowest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> ((pend_i & below) == '0));
  p_irq_vld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == vld_o);
endmodule

// File: rtl/evt_irq_aggr.sv
module evt_irq_aggr
  import evt_irq_pkg::*;
#(
  parameter int unsigned WORDS  = WORDS_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned LINES  = LINES_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  localparam int unsigned EVT_N = WORDS * WORD_W,
  localparam int unsigned IDX_W = $clog2(EVT_N),
  localparam int unsigned VEC_BASE = GRP_STRIDE * (LINES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_N-1:0]  evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [LINES-1:0]  irq_o
);
  logic [EVT_N-1:0] status;
  logic [EVT_N-1:0] clr;
  logic [EVT_N-1:0] mask    [LINES];
  logic [LINES-1:0] vec_vld;
  logic [IDX_W-1:0] vec_idx [LINES];

  // status write-1-to-clear decode
  for (genvar w = 0; w < WORDS; w++) begin : g_clr
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(4 * w);
    assign clr[w*WORD_W +: WORD_W] = (we_i && addr_i == ST_A) ? wdata_i : '0;
  end

  evt_status_bank #(.EVT_N(EVT_N)) u_status (
    .clk_i, .rst_ni, .evt_i, .clr_i(clr), .status_o(status)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [WORDS-1:0] wr;
    for (genvar w = 0; w < WORDS; w++) begin : g_wr
      localparam logic [ADDR_W-1:0] MK_A = ADDR_W'(GRP_STRIDE * (g + 1) + 4 * w);
      assign wr[w] = we_i && addr_i == MK_A;
    end

    evt_mask_bank #(.WORDS(WORDS), .WORD_W(WORD_W)) u_mask (
      .clk_i, .rst_ni, .wr_i(wr), .wdata_i, .mask_o(mask[g])
    );

    evt_line_scan #(.EVT_N(EVT_N)) u_scan (
      .clk_i, .rst_ni, .pend_i(status & mask[g]),
      .irq_o(irq_o[g]), .vld_o(vec_vld[g]), .idx_o(vec_idx[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < WORDS; w++)
      if (addr_i == ADDR_W'(4 * w)) rdata_o = status[w*WORD_W +: WORD_W];
    for (int g = 0; g < LINES; g++) begin
      for (int w = 0; w < WORDS; w++)
        if (addr_i == ADDR_W'(GRP_STRIDE * (g + 1) + 4 * w))
          rdata_o = mask[g][w*WORD_W +: WORD_W];
      if (addr_i == ADDR_W'(VEC_BASE + 4 * g)) begin
        rdata_o[IDX_W-1:0] = vec_idx[g];
        rdata_o[7]         = vec_vld[g];
      end
    end
  end

  p_irq_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> (irq_o == '0));
endmodule

// File: tb/evt_irq_aggr_bench.sv
module evt_irq_aggr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] b_evt = '0;
  logic [7:0]  b_addr = '0;
  logic        b_we = 1'b0;
  logic [31:0] b_wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_st [3];
  logic [31:0] m_mk [3][3];

  always #4 clk = ~clk;

  evt_irq_aggr u_evt_irq_aggr (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(b_evt), .addr_i(b_addr),
    .we_i(b_we), .wdata_i(b_wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] m_read(logic [7:0] a);
    for (int k = 0; k < 3; k++) if (a == 8'(4 * k)) return m_st[k];
    for (int g = 0; g < 3; g++)
      for (int k = 0; k < 3; k++) if (a == 8'(16 * (g + 1) + 4 * k)) return m_mk[g][k];
    for (int g = 0; g < 3; g++)
      if (a == 8'(64 + 4 * g)) begin
        for (int n = 0; n < 96; n++)
          if (m_st[n / 32][n % 32] && m_mk[g][n / 32][n % 32]) return 32'h80 | 32'(n);
        return 32'h0;
      end
    return 32'h0;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a < 8'h0C && a[1:0] == 2'b00) return "R1";
    if (a >= 8'h10 && a < 8'h40 && a[3:0] < 4'hC && a[1:0] == 2'b00) return "R5";
    if (a >= 8'h40 && a < 8'h4C && a[1:0] == 2'b00) return "R7";
    return "R8";
  endfunction

  function automatic logic [2:0] m_irq();
    logic [2:0] r = '0;
    for (int g = 0; g < 3; g++)
      for (int k = 0; k < 3; k++) if ((m_st[k] & m_mk[g][k]) != 0) r[g] = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step();
    for (int k = 0; k < 3; k++) begin
      logic [31:0] c = (b_we && b_addr == 8'(4 * k)) ? b_wdata : 32'h0;
      m_st[k] = (m_st[k] & ~c) | b_evt[32*k +: 32];
    end
    if (b_we)
      for (int g = 0; g < 3; g++)
        for (int k = 0; k < 3; k++) if (b_addr == 8'(16 * (g + 1) + 4 * k)) m_mk[g][k] = b_wdata;
  endtask

  // one clock: compare at falling edge, drive, advance model at rising edge
  task automatic cyc(logic [95:0] e, logic we, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    chk("R6", 32'(irq), 32'(m_irq()));
    chk(tag_of(b_addr), rdata, m_read(b_addr));
    b_evt = e; b_we = we; b_addr = a; b_wdata = d;
    @(posedge clk);
    model_step();
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    cyc('0, 1'b0, a, 32'h0);
    @(negedge clk);
    chk(req, rdata, exp);
  endtask

  function automatic logic [95:0] ev(int n);
    return 96'(1) << n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      m_st[k] = '0;
      for (int g = 0; g < 3; g++) m_mk[g][k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", 32'(irq), 32'h0);
    rst_n = 1'b1;
    // R9 reset values
    rd(8'h00, 32'h0, "R9"); rd(8'h08, 32'h0, "R9");
    rd(8'h10, 32'h0, "R9"); rd(8'h38, 32'h0, "R9");
    // R5 mask programming
    cyc('0, 1'b1, 8'h10, 32'h0000_0010);
    cyc('0, 1'b1, 8'h24, 32'hFFFF_0000);
    cyc('0, 1'b1, 8'h30, 32'hFFFF_FFFF);
    cyc('0, 1'b1, 8'h34, 32'hFFFF_FFFF);
    cyc('0, 1'b1, 8'h38, 32'hFFFF_FFFF);
    rd(8'h24, 32'hFFFF_0000, "R5");
    rd(8'h10, 32'h0000_0010, "R5");
    // R1 event 4 sets status, lines A and C
    cyc(ev(4), 1'b0, 8'h00, 32'h0);
    @(negedge clk);
    chk("R1", rdata, 32'h10);
    chk("R6", 32'(irq), 32'h5);
    rd(8'h40, 32'h84, "R7"); rd(8'h44, 32'h0, "R7"); rd(8'h48, 32'h84, "R7");
    // R7 lowest wins across words
    cyc(ev(95), 1'b0, 8'h08, 32'h0);
    @(negedge clk);
    chk("R1", rdata, 32'h8000_0000);
    rd(8'h48, 32'h84, "R7");
    // R2 writing zero leaves bits
    cyc('0, 1'b1, 8'h00, 32'h0);
    rd(8'h00, 32'h10, "R2");
    // R3 clear, line A drops
    cyc('0, 1'b1, 8'h00, 32'h10);
    rd(8'h00, 32'h0, "R3");
    chk("R6", 32'(irq), 32'h4);
    rd(8'h48, 32'hDF, "R7");
    // R4 set wins over clear
    cyc(ev(40), 1'b0, 8'h04, 32'h0);
    cyc(ev(40), 1'b1, 8'h04, 32'h100);
    rd(8'h04, 32'h100, "R4");
    cyc('0, 1'b1, 8'h04, 32'h100);
    rd(8'h04, 32'h0, "R3");
    // R6 line B via event 48, then drop by masking
    cyc(ev(48), 1'b0, 8'h44, 32'h0);
    @(negedge clk);
    chk("R6", 32'(irq[1]), 32'h1);
    chk("R7", rdata, 32'hB0);
    cyc('0, 1'b1, 8'h24, 32'h0);
    @(negedge clk);
    chk("R6", 32'(irq[1]), 32'h0);
    // R8 unmapped
    cyc('0, 1'b1, 8'h1C, 32'hFFFF_FFFF);
    cyc('0, 1'b1, 8'h0C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h0, "R8"); rd(8'h4C, 32'h0, "R8"); rd(8'hFC, 32'h0, "R8");
    rd(8'h10, 32'h10, "R8");
    rd(8'h08, 32'h8000_0000, "R8");
    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [95:0] e;
      logic [7:0]  a;
      for (int k = 0; k < 3; k++) e[32*k +: 32] = $urandom & $urandom & $urandom & $urandom;
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'(4 * ($urandom % 19));
      cyc(e, ($urandom % 4) == 0, a, $urandom);
    end
    cyc('0, 1'b0, 8'h00, 32'h0);
    cyc('0, 1'b0, 8'h00, 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule